// File: doc/BRIEF.md
# Dual-Window Protection Control Registers

This block is the register file that configures a set of peripheral protection controllers. It serves two 4 KB register windows on one request bus. A window-select bit tells it which one an access targets. The secure window holds these settings:

- for every controller, a per-port mask that marks ports as non-secure;
- for every controller, a per-port mask of privilege settings that apply to secure ports;
- an interrupt status register, an interrupt enable register and a write-only clear register;
- a one-bit bus response configuration.

The non-secure window exposes only a second set of privilege masks, which apply to ports marked non-secure. Both windows end with a run of read-only identification words.

There are ten controllers, in three families. Controllers 0 and 1 are internal APB. Controllers 2 to 5 are APB expansion. Controllers 6 to 9 are AHB expansion. For each controller the block drives its non-secure mask and an effective privilege mask. It also drives an interrupt-enable line and a one-cycle interrupt-clear pulse. It samples one interrupt line per controller into the status register. Requests are always accepted. Each response comes back one cycle later with read data and an error flag.

Top module: `prot_ctl_regs`

## Requirements
- R1: `req_ready` is always 1. Every cycle with `req_valid` high produces `rsp_valid` high in the next cycle. A cycle without `req_valid` produces `rsp_valid` low in the next cycle.
- R2: After reset, all outputs are 0, and every mask, enable, status and response-configuration register reads 0.
- R3: The secure non-secure masks live at three groups of word offsets, each holding one register per controller.
  - 0x60–0x6C hold controllers 6–9.
  - 0x70 and 0x74 hold controllers 0 and 1.
  - 0x80–0x8C hold controllers 2–5.
  - Within a group, address bits [3:2] give the position.
  - A word write stores bits [CTL_PORTS-1:0] of the data, and the stored value appears on `ns_o[c*CTL_PORTS +: CTL_PORTS]` for controller c.
- R4: Offsets 0xA0–0xAC (controllers 6–9), 0xB0/0xB4 (controllers 0–1) and 0xC0–0xCC (controllers 2–5) hold two separate masks, one per window.
  - In the secure window (`req_win`=0) they hold the secure privilege masks.
  - In the non-secure window (`req_win`=1) they hold the non-secure privilege masks.
  - No access through the non-secure window changes `ns_o`, `irq_en_o`, `irq_clr_o` or `resp_cfg_o`.
- R5: For each port bit, `ap_o` equals the non-secure privilege bit when the port's `ns_o` bit is 1. Otherwise it equals the secure privilege bit.
- R6: A write with `req_size` 0 (byte) or 1 (halfword) changes nothing and returns `rsp_err`=0 at any offset. `req_size` 2 or 3 is a word access.
- R7: A read returns the aligned 32-bit word shifted right by 8×`req_addr[1:0]`. The result is truncated to 8 bits for a byte read and to 16 bits for a halfword read.
- R8: The secure enable register at 0x28 keeps only the bits set in 0x00F0_00F3; all other bits read 0. `irq_en_o[c]` is the enable bit at controller c's status position.
- R9: The status register at secure offset 0x20 holds `irq_in[c]` at bit position p(c), registered on each clock. The positions are:
  - p = c for controllers 0–1;
  - p = 2 + c for controllers 2–5;
  - p = 14 + c for controllers 6–9.
- R10: A word write to secure offset 0x24 raises `irq_clr_o[c]` for exactly the one cycle after the write, for each c whose data bit p(c) is 1. A read of 0x24 returns an error.
- R11: A word write to secure offset 0x10 stores data bit 0. `resp_cfg_o` follows the stored bit, which reads back in bit 0.
- R12: Some accesses return `rsp_err`=1 with read data 0 and change no state:
  - word writes to the status register or to identification words;
  - any access to an offset that is not mapped in the addressed window.
- R13: Words 0xFD0–0xFFC of both windows read identification bytes in bits [7:0].
  - 0xFD0 reads 0x04 and 0xFD4–0xFDC read 0x00.
  - 0xFE0 reads the part number: 0x61 in the secure window and 0x62 in the non-secure window.
  - 0xFE4, 0xFE8 and 0xFEC read 0xA0, 0x1B and 0x00.
  - 0xFF0, 0xFF4, 0xFF8 and 0xFFC read 0x0D, 0xF0, 0x05 and 0xB1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1 |
| req_win | input | 1 | 0 = secure window, 1 = non-secure window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the window |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data |
| irq_in | input | 10 | Interrupt level from each controller |
| ns_o | output | 10×CTL_PORTS | Non-secure masks, controller c at c×CTL_PORTS |
| ap_o | output | 10×CTL_PORTS | Effective privilege masks |
| irq_en_o | output | 10 | Interrupt enable per controller |
| irq_clr_o | output | 10 | One-cycle interrupt clear per controller |
| resp_cfg_o | output | 1 | Response configuration bit |

## Verification
A decode slip shows up at the ports on the first clock edge after the offending write. Examples are a wrong controller index from address bits [3:2], a window aliasing onto the wrong mask set, or a status bit placed at the wrong position. The effect is a changed slice of `ns_o`/`ap_o` or a wrong `irq_en_o`/`irq_clr_o` bit, and the next read returns the wrong word. A stored value that a narrow or non-secure write corrupted is caught at the port slices in the cycle after that write. A stale status bit is visible one request later.

// File: rtl/prot_ctl_pkg.sv
// Shared constants, register-kind decode type and helper functions for the
// dual-window protection control register file.
package prot_ctl_pkg;

    localparam int N_APB_INT = 2;
    localparam int N_APB_EXP = 4;
    localparam int N_AHB_EXP = 4;
    localparam int NCTL      = N_APB_INT + N_APB_EXP + N_AHB_EXP;
    localparam logic [31:0] EN_KEEP = 32'h00F0_00F3;
    localparam logic [9:0]  ID_BASE_W = 10'h3F4;   // word index of 0xFD0

    typedef enum logic [3:0] {
        RK_NONE, RK_RESP, RK_STAT, RK_CLR, RK_EN,
        RK_NS, RK_SP, RK_NSP, RK_ID
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [3:0]  idx;   // controller index or identification word index
    } reg_sel_t;

    // Status/enable/clear bit position of controller c.
    function automatic int irq_pos(input int c);
        if (c < N_APB_INT)
            return c;
        else if (c < N_APB_INT + N_APB_EXP)
            return 4 + (c - N_APB_INT);
        else
            return 20 + (c - N_APB_INT - N_APB_EXP);
    endfunction

    // Identification byte for word index k; only word 4 carries the part number.
    function automatic logic [7:0] id_byte(input logic [3:0] k, input logic [7:0] pn);
        case (k)
            4'd0:    return 8'h04;
            4'd4:    return pn;
            4'd5:    return 8'hA0;
            4'd6:    return 8'h1B;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/pc_addr_decode.sv
// Address decoder: maps (window, byte offset) to a register kind and index.
// Assumes the offset is word aligned by ignoring bits [1:0]; the controller
// index inside each 16-byte group comes from bits [3:2].
module pc_addr_decode
    import prot_ctl_pkg::*;
(
    input  logic        win,
    input  logic [11:0] addr,
    output reg_sel_t    sel
);

    logic [7:0] grp;
    logic [1:0] sub;
    logic [9:0] id_w;

    assign grp  = addr[11:4];
    assign sub  = addr[3:2];
    assign id_w = addr[11:2] - ID_BASE_W;

    // Combinational decode of the two windows.
    always_comb begin
        sel.kind = RK_NONE;
        sel.idx  = 4'd0;
        if (addr[11:2] >= ID_BASE_W) begin
            sel.kind = RK_ID;
            sel.idx  = id_w[3:0];
        end else begin
            case (grp)
                8'h0A: begin
                    sel.kind = win ? RK_NSP : RK_SP;
                    sel.idx  = 4'd6 + {2'b00, sub};
                end
                8'h0B: begin
                    if (!sub[1]) begin
                        sel.kind = win ? RK_NSP : RK_SP;
                        sel.idx  = {2'b00, sub};
                    end
                end
                8'h0C: begin
                    sel.kind = win ? RK_NSP : RK_SP;
                    sel.idx  = 4'd2 + {2'b00, sub};
                end
                8'h01: begin
                    if (!win && sub == 2'd0) sel.kind = RK_RESP;
                end
                8'h02: begin
                    if (!win) begin
                        case (sub)
                            2'd0:    sel.kind = RK_STAT;
                            2'd1:    sel.kind = RK_CLR;
                            2'd2:    sel.kind = RK_EN;
                            default: sel.kind = RK_NONE;
                        endcase
                    end
                end
                8'h06: begin
                    if (!win) begin
                        sel.kind = RK_NS;
                        sel.idx  = 4'd6 + {2'b00, sub};
                    end
                end
                8'h07: begin
                    if (!win && !sub[1]) begin
                        sel.kind = RK_NS;
                        sel.idx  = {2'b00, sub};
                    end
                end
                8'h08: begin
                    if (!win) begin
                        sel.kind = RK_NS;
                        sel.idx  = 4'd2 + {2'b00, sub};
                    end
                end
                default: sel.kind = RK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/pc_mask_bank.sv
// Per-controller mask storage: non-secure, secure-privilege and
// non-secure-privilege masks, plus the effective privilege selection.
// Assumes at most one write enable per controller is high in a cycle.
module pc_mask_bank #(
    parameter int NC = 10,
    parameter int P  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NC-1:0]   we_ns,
    input  logic [NC-1:0]   we_sp,
    input  logic [NC-1:0]   we_nsp,
    input  logic [P-1:0]    wdata,
    output logic [NC*P-1:0] ns_flat,
    output logic [NC*P-1:0] sp_flat,
    output logic [NC*P-1:0] nsp_flat,
    output logic [NC*P-1:0] ap_flat
);

    for (genvar c = 0; c < NC; c++) begin : g_ctl
        logic [P-1:0] ns_q, sp_q, nsp_q;

        // Mask registers for one controller.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ns_q  <= '0;
                sp_q  <= '0;
                nsp_q <= '0;
            end else begin
                if (we_ns[c])  ns_q  <= wdata;
                if (we_sp[c])  sp_q  <= wdata;
                if (we_nsp[c]) nsp_q <= wdata;
            end
        end

        assign ns_flat[c*P +: P]  = ns_q;
        assign sp_flat[c*P +: P]  = sp_q;
        assign nsp_flat[c*P +: P] = nsp_q;
        // Per port: non-secure ports take the non-secure privilege bit.
        assign ap_flat[c*P +: P]  = (ns_q & nsp_q) | (~ns_q & sp_q);
    end

endmodule

// File: rtl/pc_irq_resp.sv
// Interrupt status sampling, enable register, clear pulses and the response
// configuration bit. Assumes write enables are already qualified as legal
// word writes in the secure window.
module pc_irq_resp
    import prot_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_we,
    input  logic            clr_we,
    input  logic            resp_we,
    input  logic [31:0]     wdata,
    input  logic [NCTL-1:0] irq_in,
    output logic [31:0]     status_word,
    output logic [31:0]     enable_word,
    output logic            resp_cfg,
    output logic [NCTL-1:0] irq_en,
    output logic [NCTL-1:0] irq_clr
);

    logic [31:0]     stat_d;
    logic [NCTL-1:0] clr_d;

    // Place each interrupt level and clear bit at its mapped position.
    always_comb begin
        stat_d = '0;
        for (int c = 0; c < NCTL; c++) begin
            stat_d[irq_pos(c)] = irq_in[c];
            clr_d[c]           = clr_we & wdata[irq_pos(c)];
        end
    end

    // Status, enable, clear pulse and response configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_word <= '0;
            enable_word <= '0;
            irq_clr     <= '0;
            resp_cfg    <= 1'b0;
        end else begin
            status_word <= stat_d;
            irq_clr     <= clr_d;
            if (en_we)   enable_word <= wdata & EN_KEEP;
            if (resp_we) resp_cfg    <= wdata[0];
        end
    end

    for (genvar c = 0; c < NCTL; c++) begin : g_en
        assign irq_en[c] = enable_word[irq_pos(c)];
    end

endmodule

// File: rtl/prot_ctl_regs.sv
// Top: dual-window protection control register file. Accepts one request
// per cycle and answers one cycle later. Word writes only; narrow writes are
// dropped silently. Reads return byte lanes of the aligned word.
module prot_ctl_regs
    import prot_ctl_pkg::*;
#(
    parameter int          CTL_PORTS = 16,
    parameter logic [7:0]  PN_SEC    = 8'h61,
    parameter logic [7:0]  PN_NSEC   = 8'h62
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_win,
    input  logic                      req_write,
    input  logic [11:0]               req_addr,
    input  logic [1:0]                req_size,
    input  logic [31:0]               req_wdata,
    output logic                      rsp_valid,
    output logic                      rsp_err,
    output logic [31:0]               rsp_rdata,
    input  logic [NCTL-1:0]           irq_in,
    output logic [NCTL*CTL_PORTS-1:0] ns_o,
    output logic [NCTL*CTL_PORTS-1:0] ap_o,
    output logic [NCTL-1:0]           irq_en_o,
    output logic [NCTL-1:0]           irq_clr_o,
    output logic                      resp_cfg_o
);

    localparam int P = CTL_PORTS;

    reg_sel_t               sel;
    logic                   is_word, writable, readable, err_now, commit;
    logic [NCTL-1:0]        we_ns, we_sp, we_nsp;
    logic [NCTL*P-1:0]      ns_flat, sp_flat, nsp_flat;
    logic [31:0]            status_word, enable_word;
    logic [31:0]            rword, shifted, rd_now;

    assign req_ready = 1'b1;

    pc_addr_decode u_dec (
        .win  (req_win),
        .addr (req_addr),
        .sel  (sel)
    );

    // Legality of the access for the decoded register kind.
    always_comb begin
        is_word  = req_size[1];
        writable = sel.kind inside {RK_RESP, RK_CLR, RK_EN, RK_NS, RK_SP, RK_NSP};
        readable = !(sel.kind inside {RK_NONE, RK_CLR});
        if (req_write) err_now = is_word && !writable;
        else           err_now = !readable;
        commit = req_valid && req_write && is_word && writable;
    end

    // Per-controller write enables.
    always_comb begin
        for (int c = 0; c < NCTL; c++) begin
            we_ns[c]  = commit && sel.kind == RK_NS  && int'(sel.idx) == c;
            we_sp[c]  = commit && sel.kind == RK_SP  && int'(sel.idx) == c;
            we_nsp[c] = commit && sel.kind == RK_NSP && int'(sel.idx) == c;
        end
    end

    pc_mask_bank #(.NC(NCTL), .P(P)) u_masks (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_ns    (we_ns),
        .we_sp    (we_sp),
        .we_nsp   (we_nsp),
        .wdata    (req_wdata[P-1:0]),
        .ns_flat  (ns_flat),
        .sp_flat  (sp_flat),
        .nsp_flat (nsp_flat),
        .ap_flat  (ap_o)
    );

    pc_irq_resp u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_we       (commit && sel.kind == RK_EN),
        .clr_we      (commit && sel.kind == RK_CLR),
        .resp_we     (commit && sel.kind == RK_RESP),
        .wdata       (req_wdata),
        .irq_in      (irq_in),
        .status_word (status_word),
        .enable_word (enable_word),
        .resp_cfg    (resp_cfg_o),
        .irq_en      (irq_en_o),
        .irq_clr     (irq_clr_o)
    );

    assign ns_o = ns_flat;

    // Read word selection, lane shift and size truncation.
    always_comb begin
        rword = '0;
        case (sel.kind)
            RK_RESP: rword = {31'b0, resp_cfg_o};
            RK_STAT: rword = status_word;
            RK_EN:   rword = enable_word;
            RK_NS:   rword = 32'(ns_flat[int'(sel.idx)*P +: P]);
            RK_SP:   rword = 32'(sp_flat[int'(sel.idx)*P +: P]);
            RK_NSP:  rword = 32'(nsp_flat[int'(sel.idx)*P +: P]);
            RK_ID:   rword = {24'b0, id_byte(sel.idx, req_win ? PN_NSEC : PN_SEC)};
            default: rword = '0;
        endcase
        shifted = rword >> {req_addr[1:0], 3'b000};
        case (req_size)
            2'd0:    rd_now = {24'b0, shifted[7:0]};
            2'd1:    rd_now = {16'b0, shifted[15:0]};
            default: rd_now = shifted;
        endcase
    end

    // Registered response, one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && err_now;
            rsp_rdata <= (req_valid && !req_write && !err_now) ? rd_now : 32'b0;
        end
    end

endmodule

// File: rtl/prot_ctl_regs_chk.sv
// Port-level checker for prot_ctl_regs, attached by bind.
module prot_ctl_regs_chk #(
    parameter int CTL_PORTS = 16,
    parameter int NC        = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_win,
    input logic                    req_write,
    input logic [11:0]             req_addr,
    input logic [1:0]              req_size,
    input logic                    rsp_valid,
    input logic                    rsp_err,
    input logic [NC*CTL_PORTS-1:0] ns_o,
    input logic [NC*CTL_PORTS-1:0] ap_o,
    input logic [NC-1:0]           irq_en_o,
    input logic [NC-1:0]           irq_clr_o,
    input logic                    resp_cfg_o
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_NS_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ns_o) |-> $past(req_valid && req_write && !req_win && req_size[1])); // R3
    AST_NSWIN_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_win) |=>
        ($stable(ns_o) && $stable(resp_cfg_o) && $stable(irq_en_o) && irq_clr_o == '0)); // R4
    AST_NARROW_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_size[1]) |=>
        ($stable(ns_o) && $stable(ap_o) && $stable(resp_cfg_o) && $stable(irq_en_o)
         && irq_clr_o == '0 && !rsp_err)); // R6
    AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_o != '0) |-> $past(req_valid && req_write && !req_win && req_size[1]
                                     && req_addr[11:2] == 10'h009)); // R10
    AST_RESP_CFG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(resp_cfg_o) |-> $past(req_valid && req_write && !req_win && req_size[1]
                                        && req_addr[11:2] == 10'h004)); // R11
    AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid); // R12

endmodule

bind prot_ctl_regs prot_ctl_regs_chk #(.CTL_PORTS(CTL_PORTS), .NC(prot_ctl_pkg::NCTL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_win    (req_win),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .ns_o       (ns_o),
    .ap_o       (ap_o),
    .irq_en_o   (irq_en_o),
    .irq_clr_o  (irq_clr_o),
    .resp_cfg_o (resp_cfg_o)
);

// File: tb/test_prot_ctl_regs.sv
// Directed bench for prot_ctl_regs; one task per scenario.
module test_prot_ctl_regs;

    localparam int P  = 16;
    localparam int NC = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_win = 1'b0;
    logic          req_write = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [1:0]    req_size = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid, rsp_err;
    logic [31:0]   rsp_rdata;
    logic [NC-1:0] irq_in = '0;
    logic [NC*P-1:0] ns_o, ap_o;
    logic [NC-1:0] irq_en_o, irq_clr_o;
    logic          resp_cfg_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    prot_ctl_regs #(.CTL_PORTS(P)) i_prot_ctl_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_win(req_win), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .irq_in(irq_in), .ns_o(ns_o),
        .ap_o(ap_o), .irq_en_o(irq_en_o), .irq_clr_o(irq_clr_o),
        .resp_cfg_o(resp_cfg_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus access; result sampled at the negedge after the capturing edge.
    task automatic acc(input logic win, input logic wr, input logic [11:0] a,
                       input logic [1:0] sz, input logic [31:0] wd,
                       output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_win = win; req_write = wr;
        req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata; er = rsp_err;
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    endtask

    function automatic logic [31:0] ns_of(input int c);
        return 32'(ns_o[c*P +: P]);
    endfunction

    task automatic t_reset();
        logic [31:0] rd; logic er;
        chk("R2 ns_o", {31'b0, |ns_o}, 0);
        chk("R2 ap_o", {31'b0, |ap_o}, 0);
        chk("R2 irq outs", {22'b0, irq_en_o}, 0);
        chk("R2 resp_cfg_o", {31'b0, resp_cfg_o}, 0);
        chk("R1 ready", {31'b0, req_ready}, 1);
        acc(0, 0, 12'h028, 2, 0, rd, er);
        chk("R2 enable reads 0", rd, 0);
        @(negedge clk);
        chk("R1 no rsp without req", {31'b0, rsp_valid}, 0);
        acc(1, 0, 12'h0C4, 2, 0, rd, er);
        chk("R2 nsp reads 0", rd, 0);
    endtask

    task automatic t_ns_masks();
        logic [31:0] rd; logic er;
        acc(0, 1, 12'h064, 2, 32'hFFFF_A5C3, rd, er);
        chk("R3 ctl7 ns_o", ns_of(7), 32'hA5C3);
        acc(0, 1, 12'h074, 2, 32'h0000_1234, rd, er);
        chk("R3 ctl1 ns_o", ns_of(1), 32'h1234);
        acc(0, 1, 12'h088, 2, 32'h0000_0F0F, rd, er);
        chk("R3 ctl4 ns_o", ns_of(4), 32'h0F0F);
        chk("R3 ctl6 untouched", ns_of(6), 0);
        acc(0, 0, 12'h064, 2, 0, rd, er);
        chk("R3 readback ctl7", rd, 32'hA5C3);
    endtask

    task automatic t_priv_and_ap();
        logic [31:0] rd; logic er;
        logic [15:0] nsv, spv, nspv;
        spv = 16'h00FF; nspv = 16'h0F0F; nsv = 16'h3C3C;
        acc(0, 1, 12'h0B0, 2, {16'h0, spv}, rd, er);
        acc(1, 1, 12'h0B0, 2, {16'h0, nspv}, rd, er);
        acc(0, 0, 12'h0B0, 2, 0, rd, er);
        chk("R4 secure priv readback", rd, {16'h0, spv});
        acc(1, 0, 12'h0B0, 2, 0, rd, er);
        chk("R4 non-secure priv readback", rd, {16'h0, nspv});
        chk("R5 ap all-secure", 32'(ap_o[0 +: P]), {16'h0, spv});
        acc(0, 1, 12'h070, 2, {16'h0, nsv}, rd, er);
        chk("R5 ap mixed", 32'(ap_o[0 +: P]), {16'h0, (nsv & nspv) | (~nsv & spv)});
    endtask

    task automatic t_narrow_and_lanes();
        logic [31:0] rd; logic er;
        acc(0, 1, 12'h070, 0, 32'h0, rd, er);
        chk("R6 byte write err", {31'b0, er}, 0);
        chk("R6 byte write ignored", ns_of(0), 32'h3C3C);
        acc(0, 1, 12'h064, 1, 32'h0, rd, er);
        chk("R6 half write ignored", ns_of(7), 32'hA5C3);
        acc(0, 0, 12'h065, 0, 0, rd, er);
        chk("R7 byte lane 1", rd, 32'hA5);
        acc(0, 0, 12'h064, 0, 0, rd, er);
        chk("R7 byte lane 0", rd, 32'hC3);
        acc(0, 0, 12'h064, 1, 0, rd, er);
        chk("R7 half lane 0", rd, 32'hA5C3);
        acc(0, 0, 12'h066, 1, 0, rd, er);
        chk("R7 half lane 1", rd, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] rd; logic er;
        acc(0, 1, 12'h028, 2, 32'hFFFF_FFFF, rd, er);
        acc(0, 0, 12'h028, 2, 0, rd, er);
        chk("R8 enable mask", rd, 32'h00F0_00F3);
        chk("R8 all enables", {22'b0, irq_en_o}, 32'h3FF);
        acc(0, 1, 12'h028, 2, 32'h0010_0002, rd, er);
        chk("R8 enable ctl1+ctl6", {22'b0, irq_en_o}, 32'h042);
    endtask

    task automatic t_status();
        logic [31:0] rd; logic er;
        @(negedge clk);
        irq_in = 10'b10_0001_0001;
        acc(0, 0, 12'h020, 2, 0, rd, er);
        chk("R9 status positions", rd, 32'h0080_0041);
        acc(0, 1, 12'h020, 2, 32'hFFFF_FFFF, rd, er);
        chk("R12 status write err", {31'b0, er}, 1);
        irq_in = '0;
        acc(0, 0, 12'h020, 2, 0, rd, er);
        chk("R9 status follows level", rd, 0);
    endtask

    task automatic t_clear();
        logic [31:0] rd; logic er;
        acc(0, 1, 12'h024, 2, 32'h0020_0010, rd, er);
        chk("R10 clear pulse", {22'b0, irq_clr_o}, 32'h084);
        @(negedge clk);
        chk("R10 clear one cycle", {22'b0, irq_clr_o}, 0);
        acc(0, 0, 12'h024, 2, 0, rd, er);
        chk("R10 clear read err", {31'b0, er}, 1);
    endtask

    task automatic t_resp_and_errors();
        logic [31:0] rd; logic er;
        acc(0, 1, 12'h010, 2, 32'h0000_0001, rd, er);
        chk("R11 resp_cfg_o", {31'b0, resp_cfg_o}, 1);
        acc(0, 0, 12'h010, 2, 0, rd, er);
        chk("R11 resp readback", rd, 1);
        acc(1, 1, 12'h010, 2, 32'h0, rd, er);
        chk("R12 ns window unmapped err", {31'b0, er}, 1);
        chk("R4 resp unchanged by ns window", {31'b0, resp_cfg_o}, 1);
        acc(1, 1, 12'h070, 2, 32'h0, rd, er);
        chk("R4 ns window cannot write ns mask", ns_of(0), 32'h3C3C);
        acc(0, 0, 12'h100, 2, 0, rd, er);
        chk("R12 unmapped read err", {31'b0, er}, 1);
        chk("R12 unmapped read data", rd, 0);
        acc(0, 1, 12'hFE0, 2, 32'hFF, rd, er);
        chk("R12 id write err", {31'b0, er}, 1);
    endtask

    task automatic t_id();
        logic [31:0] rd; logic er;
        acc(0, 0, 12'hFE0, 2, 0, rd, er);
        chk("R13 secure part number", rd, 32'h61);
        acc(1, 0, 12'hFE0, 2, 0, rd, er);
        chk("R13 non-secure part number", rd, 32'h62);
        acc(0, 0, 12'hFD0, 2, 0, rd, er);
        chk("R13 first id word", rd, 32'h04);
        acc(1, 0, 12'hFFC, 2, 0, rd, er);
        chk("R13 last id word", rd, 32'hB1);
        acc(0, 0, 12'hFE8, 2, 0, rd, er);
        chk("R13 id word FE8", rd, 32'h1B);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ns_masks();
        t_priv_and_ap();
        t_narrow_and_lanes();
        t_enable();
        t_status();
        t_clear();
        t_resp_and_errors();
        t_id();
        repeat (2) @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

endmodule